// File: doc/BRIEF.md
# Phase-Offset Programmable Clock Divider Channel

This block is a single output lane of a clock fan-out stage. It divides a source clock by an integer from 1 to 1024. It can also delay the divided waveform by a number of half source periods, invert it, or power it down. The block runs on a tick clock at twice the source frequency, so that each tick is one half period of the source. An integer divide ratio N therefore gives an output period of 2N ticks, with N ticks high and N ticks low. This is exactly 50% for odd and even ratios, and for N = 1 the output copies the source clock.

Settings arrive as a 24-bit channel word, which is latched on a one-cycle load strobe. Inversion, power-down and the sync-ignore flag act as soon as the word is latched. A new ratio is adopted at the end of the running output period or when a sync is released. A new phase code is adopted when a sync is released. A global sync level holds every non-ignoring channel low. When the sync level drops, each such channel waits its own phase delay and then restarts its divider, so all channels realign.

The sequencer has three states:

- HOLD: sync is asserted, and the output is low.
- DELAY: the phase delay counts down, and the output is low.
- RUN: the divider is running.

The transitions are:

- HOLD→DELAY when sync drops. This is the release, and it loads the phase count and the latched ratio.
- DELAY→RUN when the phase count is zero.
- DELAY→HOLD and RUN→HOLD when sync is asserted.
- Reset enters DELAY with a zero count.

Top module: `chd_top`

## Requirements
- R1: While reset is asserted, `clk_out` is 0 and `drv_mode` and `low_power` are 0. The latched word resets to all zeros.
- R2: The word's bits 17:8 hold the ratio minus one (N−1). In RUN the output repeats a pattern of N ticks high followed by N ticks low.
- R3: With bits 17:8 equal to 0, the output in RUN changes level on every tick.
- R4: The word's bits 23:18 hold the phase code P (0..63). The release is sampled at clock edge E0. The output then stays low for P+1 ticks and goes high after edge E0+P+1.
- R5: While `sync_req` is 1 and the latched bit 6 is 0, the output is 0 from the tick after the edge that samples it.
- R6: With the latched bit 6 set to 1, `sync_req` has no effect, and a running output keeps toggling.
- R7: With the latched bit 7 set to 1, the output in RUN is the complement of the divided waveform.
- R8: With the latched bit 5 set to 1, the output is 0 from the tick after the load.
- R9: `cfg_word` acts only through `cfg_load`. A ratio latched while running takes effect after the current output period ends.
- R10: `drv_mode` shows the latched bits 3:0, and `low_power` shows the latched bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per source half period |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 24 | Channel configuration word |
| cfg_load | input | 1 | One-tick strobe that latches `cfg_word` |
| sync_req | input | 1 | Global sync level; its falling edge realigns the divider |
| clk_out | output | 1 | Divided, phased and gated clock |
| drv_mode | output | 4 | Stored driver mode field |
| low_power | output | 1 | Stored low-power flag |

## Verification
The bench releases sync with a range of ratio and phase pairs, including odd ratios, ratio 1 and the largest phase code. A design with an off-by-one in the phase count would start one tick early or late. A design with the wrong wrap point would stretch or shrink the low half. The bench changes the ratio in the middle of a period to catch a design that truncates the current period. It also presents a word without a load strobe, which catches a design that reacts to the raw input. Further tests check that ignore-sync keeps the output running, and that power-down and sync hold force the output low even when inversion is set.

// File: rtl/chd_pkg.sv
package chd_pkg;
    localparam int RATIO_W = 10;
    localparam int PHASE_W = 6;
    localparam int DRV_W   = 4;
    localparam int FLAG_W  = 4;
    localparam int WORD_W  = PHASE_W + RATIO_W + FLAG_W + DRV_W;
    localparam int TICK_W  = RATIO_W + 1;

    // Field order is the word layout: phase 23:18, ratio-1 17:8, flags 7:4, drive 3:0
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [RATIO_W-1:0] ratio_m1;
        logic               invert;
        logic               ign_sync;
        logic               pwr_dn;
        logic               low_pwr;
        logic [DRV_W-1:0]   drv;
    } chd_cfg_t;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2
    } chd_state_e;
endpackage

// File: rtl/chd_cfg_store.sv
module chd_cfg_store
    import chd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  word,
    input  logic          apply,
    output chd_cfg_t      pend,
    output logic [RW-1:0] act_ratio_m1
);
    // Latched word: flags act at once, the ratio waits for apply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (load) begin
            pend <= chd_cfg_t'(word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ratio_m1 <= '0;
        end else if (apply) begin
            act_ratio_m1 <= pend.ratio_m1;
        end
    end
endmodule

// File: rtl/chd_seq_fsm.sv
module chd_seq_fsm
    import chd_pkg::*;
#(
    parameter int PW = PHASE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_req,
    input  logic [PW-1:0] phase_in,
    output chd_state_e    state_q,
    output logic [PW-1:0] dly_q,
    output logic          release_p
);
    chd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DELAY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = hold_req ? ST_HOLD : ST_DELAY;
            ST_DELAY: state_d = hold_req ? ST_HOLD :
                                ((dly_q == '0) ? ST_RUN : ST_DELAY);
            ST_RUN:   state_d = hold_req ? ST_HOLD : ST_RUN;
            default:  state_d = ST_HOLD;
        endcase
    end

    assign release_p = (state_q == ST_HOLD) && !hold_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
        end else if (release_p) begin
            dly_q <= phase_in;
        end else if (state_q == ST_DELAY && !hold_req && dly_q != '0) begin
            dly_q <= dly_q - 1'b1;
        end
    end
endmodule

// File: rtl/chd_tick_cnt.sv
module chd_tick_cnt
    import chd_pkg::*;
#(
    parameter int RW = RATIO_W,
    parameter int TW = RW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [RW-1:0] ratio_m1,
    output logic [TW-1:0] cnt_q,
    output logic          raw,
    output logic          wrap
);
    localparam logic [TW-1:0] ONE = TW'(1);

    // Period is 2N ticks; the last tick index is 2N-1 = {N-1, 1}
    assign wrap = run && (cnt_q == {ratio_m1, 1'b1});
    assign raw  = run && (cnt_q <= {1'b0, ratio_m1});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/chd_top.sv
module chd_top
    import chd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] cfg_word,
    input  logic        cfg_load,
    input  logic        sync_req,
    output logic        clk_out,
    output logic [3:0]  drv_mode,
    output logic        low_power
);
    chd_cfg_t           pend;
    logic [RATIO_W-1:0] act_ratio_m1;
    chd_state_e         state_q;
    logic [PHASE_W-1:0] dly_q;
    logic [TICK_W-1:0]  cnt_q;
    logic               release_p;
    logic               div_raw;
    logic               wrap;
    logic               hold_req;
    logic               running;

    assign hold_req = sync_req && !pend.ign_sync;
    assign running  = (state_q == ST_RUN);

    chd_cfg_store #(.W(WORD_W), .RW(RATIO_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (cfg_load),
        .word         (cfg_word),
        .apply        (release_p || wrap),
        .pend         (pend),
        .act_ratio_m1 (act_ratio_m1)
    );

    chd_seq_fsm #(.PW(PHASE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .phase_in  (pend.phase),
        .state_q   (state_q),
        .dly_q     (dly_q),
        .release_p (release_p)
    );

    chd_tick_cnt #(.RW(RATIO_W), .TW(TICK_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .ratio_m1 (act_ratio_m1),
        .cnt_q    (cnt_q),
        .raw      (div_raw),
        .wrap     (wrap)
    );

    // Output stage: low outside RUN and when powered down
    always_comb begin
        clk_out   = running && !pend.pwr_dn && (div_raw ^ pend.invert);
        drv_mode  = pend.drv;
        low_power = pend.low_pwr;
    end
endmodule

// File: rtl/chd_checker.sv
module chd_checker
    import chd_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [23:0]        cfg_word,
    input logic               cfg_load,
    input logic               sync_req,
    input logic               clk_out,
    input chd_cfg_t           pend,
    input logic [RATIO_W-1:0] act_ratio_m1,
    input chd_state_e         state_q,
    input logic [PHASE_W-1:0] dly_q,
    input logic [TICK_W-1:0]  cnt_q,
    input logic               div_raw
);
    p_pd_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_word[5]) |=> !clk_out);

    p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_req && !pend.ign_sync && !cfg_load) |=> !clk_out);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q <= {act_ratio_m1, 1'b1}));

    p_delay_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && dly_q == '0 && !(sync_req && !pend.ign_sync))
        |=> (state_q == ST_RUN));

    p_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(pend));

    p_ratio1_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN &&
         act_ratio_m1 == '0 && $past(act_ratio_m1) == '0)
        |-> (div_raw != $past(div_raw)));
endmodule

bind chd_top chd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_word     (cfg_word),
    .cfg_load     (cfg_load),
    .sync_req     (sync_req),
    .clk_out      (clk_out),
    .pend         (pend),
    .act_ratio_m1 (act_ratio_m1),
    .state_q      (state_q),
    .dly_q        (dly_q),
    .cnt_q        (cnt_q),
    .div_raw      (div_raw)
);

// File: tb/tb_chd_top.sv
module tb_chd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        cfg_load = 1'b0;
    logic        sync_req = 1'b0;
    logic        clk_out;
    logic [3:0]  drv_mode;
    logic        low_power;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chd_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_load(cfg_load),
        .sync_req(sync_req), .clk_out(clk_out), .drv_mode(drv_mode),
        .low_power(low_power)
    );

    typedef struct packed {
        logic [9:0] r;
        logic [5:0] p;
        logic       inv;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{r: 10'd0, p: 6'd0,  inv: 1'b0},
        '{r: 10'd2, p: 6'd0,  inv: 1'b0},
        '{r: 10'd3, p: 6'd5,  inv: 1'b0},
        '{r: 10'd4, p: 6'd2,  inv: 1'b1},
        '{r: 10'd0, p: 6'd3,  inv: 1'b1},
        '{r: 10'd6, p: 6'd63, inv: 1'b0}
    };

    function automatic logic [23:0] mk(input logic [5:0] p, input logic [9:0] r,
                                       input logic inv, input logic ign,
                                       input logic pd, input logic lp,
                                       input logic [3:0] drv);
        return {p, r, inv, ign, pd, lp, drv};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load a word under sync, release, and compare the output per tick
    task automatic run_vec(input logic [9:0] r, input logic [5:0] p,
                           input logic inv, input string req);
        int n;
        int bad;
        int fa;
        int fe;
        logic ex;
        n = int'(r) + 1;
        bad = 0;
        fa = 0;
        fe = 0;
        cfg_word = mk(p, r, inv, 1'b0, 1'b0, 1'b0, 4'h0);
        cfg_load = 1'b1;
        sync_req = 1'b1;
        tick();
        cfg_load = 1'b0;
        tick();
        sync_req = 1'b0;
        tick();
        for (int k = 0; k < int'(p) + 2 * n + 2; k++) begin
            if (k > int'(p)) ex = (((k - int'(p) - 1) % (2 * n)) < n) ^ inv;
            else ex = 1'b0;
            if (clk_out !== ex && bad == 0) begin
                fa = int'(clk_out);
                fe = int'(ex) + 10 * k;
            end
            if (clk_out !== ex) bad++;
            tick();
        end
        check(bad == 0, req, fa, fe);
    endtask

    initial begin
        @(negedge clk);
        tick();
        // R1: reset state
        check(clk_out == 1'b0 && drv_mode == 4'h0 && low_power == 1'b0, "R1 reset",
              int'({clk_out, drv_mode, low_power}), 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 R7: table of ratio/phase/invert vectors
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i].r, VECS[i].p, VECS[i].inv,
                    $sformatf("R2/R3/R4/R7 vector %0d", i));
        end

        // R9: raw word without load ignored; mid-period ratio change waits for wrap
        begin
            int bad;
            logic ex;
            bad = 0;
            cfg_word = mk(6'd0, 10'd3, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
            cfg_load = 1'b1;
            sync_req = 1'b1;
            tick();
            cfg_load = 1'b0;
            tick();
            sync_req = 1'b0;
            tick();
            for (int k = 0; k < 15; k++) begin
                if (k == 0) ex = 1'b0;
                else if (k <= 8) ex = ((k - 1) % 8) < 4;
                else ex = ((k - 9) % 4) < 2;
                if (clk_out !== ex) bad++;
                if (k == 1) cfg_word = mk(6'd0, 10'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
                if (k == 2) begin
                    cfg_word = mk(6'd0, 10'd1, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
                    cfg_load = 1'b1;
                end
                if (k == 3) cfg_load = 1'b0;
                tick();
            end
            check(bad == 0, "R9 load-only and wrap-aligned ratio", bad, 0);
        end

        // R6: ignore-sync keeps a ratio-1 output toggling
        begin
            int bad;
            logic prev;
            bad = 0;
            run_vec(10'd0, 6'd0, 1'b0, "R3 ratio one restart");
            cfg_word = mk(6'd0, 10'd0, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0);
            cfg_load = 1'b1;
            tick();
            cfg_load = 1'b0;
            sync_req = 1'b1;
            prev = clk_out;
            for (int k = 0; k < 8; k++) begin
                tick();
                if (clk_out === prev) bad++;
                prev = clk_out;
            end
            sync_req = 1'b0;
            check(bad == 0, "R6 sync ignored", bad, 0);
        end

        // R5: sync hold forces low, even with inversion set
        begin
            int bad;
            bad = 0;
            cfg_word = mk(6'd0, 10'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
            cfg_load = 1'b1;
            tick();
            cfg_load = 1'b0;
            sync_req = 1'b1;
            tick();
            for (int k = 0; k < 10; k++) begin
                if (clk_out !== 1'b0) bad++;
                tick();
            end
            sync_req = 1'b0;
            check(bad == 0, "R5 sync hold low", bad, 0);
        end

        // R8: power-down forces low while running inverted
        begin
            int bad;
            bad = 0;
            run_vec(10'd1, 6'd0, 1'b1, "R7 inverted restart");
            cfg_word = mk(6'd0, 10'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0);
            cfg_load = 1'b1;
            tick();
            cfg_load = 1'b0;
            for (int k = 0; k < 10; k++) begin
                if (clk_out !== 1'b0) bad++;
                tick();
            end
            check(bad == 0, "R8 power-down low", bad, 0);
        end

        // R10: stored driver fields; unloaded word has no effect (R9)
        cfg_word = mk(6'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hA);
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
        check(drv_mode == 4'hA && low_power == 1'b1, "R10 driver fields",
              int'({low_power, drv_mode}), 'h1A);
        cfg_word = mk(6'd0, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h5);
        tick();
        check(drv_mode == 4'hA && low_power == 1'b1, "R9 R10 no load no change",
              int'({low_power, drv_mode}), 'h1A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule